// File: doc/BRIEF.md
# Lane Shuffle Crossbar

This block exchanges register values among a group of parallel lanes in a single step. Every lane receives a copy of one data word taken from another lane of the same group. One addressing mode is applied to all lanes at once: shift up, shift down, butterfly exchange, or direct index. The offset or index operand and a control word are shared by every lane. The control word carries a clamp and a sub-group mask, which split the lanes into independent segments.

For each lane the block works out a source lane and decides whether that source lies inside the lane's segment boundary. A lane with an in-range source copies that lane's word. Any other lane keeps its own word. The in-range decision is also returned as a per-lane predicate bit. If the chosen source lane is switched off in the active-lane mask, the lane receives zero instead. All lanes are resolved in parallel. The results are registered, and a done pulse follows the start strobe by one clock.

Top module: `shfl_xbar`

## Requirements
- R1: `done` is high for exactly the one cycle after a cycle in which `start` is high. `result`, `inRange` and `modeErr` change only at that edge and hold their values until the next start.
- R2: Only `offB[4:0]` is used as the offset or index. The clamp is `ctrlC[4:0]` and the segment mask is `ctrlC[12:8]`. All other bits of both operands have no effect.
- R3: Mode code 0 (up): the source is lane − offset. It is in range when it is not negative and is at least the boundary, where boundary = (lane & mask) | (clamp & ~mask).
- R4: Mode code 1 (down): the source is lane + offset. It is in range when it is at most the boundary.
- R5: Mode code 2 (butterfly): the source is lane XOR offset. It is in range when it is at most the boundary.
- R6: Mode code 3 (indexed): the source is (lane & mask) | (offset & ~mask). It is in range when it is at most the boundary.
- R7: A lane whose source is out of range takes its own lane's word. Its `inRange` bit is 0. An in-range lane has `inRange` bit 1.
- R8: When the lane finally selected (source or own lane) has its `activeMask` bit at 0, that lane's result is zero.
- R9: Mode codes 4 to 7 are illegal. They set `modeErr`, give every lane its own word (subject to R8) and clear all `inRange` bits. A legal mode clears `modeErr`.
- R10: After reset, `done`, `modeErr`, `inRange` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sample the operands and resolve all lanes |
| mode | input | 3 | Addressing mode: 0 up, 1 down, 2 butterfly, 3 indexed |
| offB | input | 32 | Offset or index operand |
| ctrlC | input | 32 | Control word: clamp in bits 4:0, segment mask in bits 12:8 |
| activeMask | input | 32 | One bit per lane, 1 marks the lane as active |
| laneData | input | 1024 | Lane words; lane k occupies bits 32k+31 to 32k |
| result | output | 1024 | Shuffled words in the same lane layout |
| inRange | output | 32 | Per-lane in-range predicate |
| done | output | 1 | Results valid, one cycle after start |
| modeErr | output | 1 | Last operation used an illegal mode code |

## Verification
The bench builds the block with its defaults: 32 lanes of 32-bit words and the mask field at bit 8. At that size the full 5-bit offset range is in use, and clamps reach up to lane 31. Segments of 8 lanes, set through mask 0x18, sit beside whole-group operation. This brings within reach the boundary lanes where up and down shifts leave a segment, negative up-shift sources, sources cut off by an inactive lane, and operand bits above the used fields.

// File: rtl/shfl_pkg.sv
package shfl_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_UP   = 3'd0,
    MODE_DOWN = 3'd1,
    MODE_BFLY = 3'd2,
    MODE_IDX  = 3'd3
  } shflMode_e;

  typedef struct packed {
    logic capture;
    logic badMode;
  } shflStrobe_t;

  function automatic logic modeLegal(input logic [MODE_W-1:0] m);
    return m <= 3'd3;
  endfunction
endpackage

// File: rtl/shfl_ctrl.sv
module shfl_ctrl
  import shfl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  output shflStrobe_t       strobe,
  output logic              done,
  output logic              modeErr
);
  always_comb begin
    strobe.capture = start;
    strobe.badMode = start && !modeLegal(mode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done    <= 1'b0;
      modeErr <= 1'b0;
    end else begin
      done <= strobe.capture;
      if (strobe.capture) modeErr <= strobe.badMode;
    end
  end

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  // R1
  done_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);
endmodule

// File: rtl/shfl_datapath.sv
module shfl_datapath
  import shfl_pkg::*;
#(
  parameter int LANES    = 32,
  parameter int DATA_W   = 32,
  parameter int OPND_W   = 32,
  parameter int MASK_LSB = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  shflStrobe_t             strobe,
  input  logic [MODE_W-1:0]       mode,
  input  logic [OPND_W-1:0]       offB,
  input  logic [OPND_W-1:0]       ctrlC,
  input  logic [LANES-1:0]        activeMask,
  input  logic [LANES*DATA_W-1:0] laneData,
  output logic [LANES*DATA_W-1:0] resultQ,
  output logic [LANES-1:0]        predQ
);
  localparam int LB = $clog2(LANES);

  logic [LB-1:0] bOff, clamp, segMask;
  logic [LANES*DATA_W-1:0] resultD;
  logic [LANES-1:0]        predD;

  assign bOff    = offB[LB-1:0];
  assign clamp   = ctrlC[LB-1:0];
  assign segMask = ctrlC[MASK_LSB +: LB];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [LB-1:0] LANE_ID = LB'(g);
    logic [LB-1:0] bound, base, sel;
    logic [LB:0]   srcW;
    logic          ok;

    assign base  = LANE_ID & segMask;
    assign bound = base | (clamp & ~segMask);

    always_comb begin
      case (mode)
        MODE_UP: begin
          srcW = {1'b0, LANE_ID} - {1'b0, bOff};
          ok   = !srcW[LB] && (srcW[LB-1:0] >= bound);
        end
        MODE_DOWN: begin
          srcW = {1'b0, LANE_ID} + {1'b0, bOff};
          ok   = !srcW[LB] && (srcW[LB-1:0] <= bound);
        end
        MODE_BFLY: begin
          srcW = {1'b0, LANE_ID ^ bOff};
          ok   = srcW[LB-1:0] <= bound;
        end
        MODE_IDX: begin
          srcW = {1'b0, base | (bOff & ~segMask)};
          ok   = srcW[LB-1:0] <= bound;
        end
        default: begin
          srcW = {1'b0, LANE_ID};
          ok   = 1'b0;
        end
      endcase
      sel = ok ? srcW[LB-1:0] : LANE_ID;
    end

    assign predD[g] = ok;
    assign resultD[g*DATA_W +: DATA_W] =
      activeMask[sel] ? laneData[sel*DATA_W +: DATA_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      predQ   <= '0;
    end else if (strobe.capture) begin
      resultQ <= resultD;
      predQ   <= predD;
    end
  end

  // R1
  hold_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(resultQ) && $stable(predQ));

  // R9
  bad_mode_pred_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.badMode |=> predQ == '0);
endmodule

// File: rtl/shfl_xbar.sv
module shfl_xbar
  import shfl_pkg::*;
#(
  parameter int LANES    = 32,
  parameter int DATA_W   = 32,
  parameter int OPND_W   = 32,
  parameter int MASK_LSB = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [MODE_W-1:0]       mode,
  input  logic [OPND_W-1:0]       offB,
  input  logic [OPND_W-1:0]       ctrlC,
  input  logic [LANES-1:0]        activeMask,
  input  logic [LANES*DATA_W-1:0] laneData,
  output logic [LANES*DATA_W-1:0] result,
  output logic [LANES-1:0]        inRange,
  output logic                    done,
  output logic                    modeErr
);
  shflStrobe_t strobe;

  shfl_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .strobe(strobe), .done(done), .modeErr(modeErr)
  );

  shfl_datapath #(
    .LANES(LANES), .DATA_W(DATA_W), .OPND_W(OPND_W), .MASK_LSB(MASK_LSB)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mode(mode),
    .offB(offB), .ctrlC(ctrlC), .activeMask(activeMask),
    .laneData(laneData), .resultQ(result), .predQ(inRange)
  );

  // R9
  err_pred_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> inRange == '0);
endmodule

// File: tb/test_shfl_xbar.sv
module test_shfl_xbar;
  localparam int LANES = 32;
  localparam int DW    = 32;

  typedef struct {
    logic [LANES*DW-1:0] res;
    logic [LANES-1:0]    pred;
    logic                err;
    string               tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [2:0] mode = '0;
  logic [31:0] offB = '0, ctrlC = '0, activeMask = '0;
  logic [LANES*DW-1:0] laneData = '0;
  logic [LANES*DW-1:0] result;
  logic [LANES-1:0] inRange;
  logic done, modeErr;

  int errors = 0;
  int checks = 0;
  int popped = 0;
  exp_t q[$];
  exp_t lastExp;

  always #2.5 clk = ~clk;

  shfl_xbar i_shfl_xbar (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .offB(offB),
    .ctrlC(ctrlC), .activeMask(activeMask), .laneData(laneData),
    .result(result), .inRange(inRange), .done(done), .modeErr(modeErr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Driver: computes expected values from the requirements, then issues.
  task automatic issue(input string tag, input logic [2:0] m, input logic [31:0] b,
                       input logic [31:0] c, input logic [31:0] act, input int seed);
    exp_t e;
    int bo, cl, mk;
    bo = int'(b & 32'h1F);
    cl = int'(c & 32'h1F);
    mk = int'((c >> 8) & 32'h1F);
    for (int k = 0; k < LANES; k++)
      laneData[k*DW +: DW] = 32'h5A00_0000 ^ (k * 32'h0101_0011) ^ (seed * 32'h0013_7000);
    e.tag = tag;
    e.err = (m > 3);
    for (int k = 0; k < LANES; k++) begin
      int maxL, src, pick;
      bit v;
      maxL = (k & mk) | (cl & ~mk & 31);
      case (m)
        3'd0: begin src = k - bo; v = (src >= 0) && (src >= maxL); end
        3'd1: begin src = k + bo; v = (src <= maxL); end
        3'd2: begin src = k ^ bo; v = (src <= maxL); end
        3'd3: begin src = (k & mk) | (bo & ~mk & 31); v = (src <= maxL); end
        default: begin src = k; v = 0; end
      endcase
      pick = v ? src : k;
      e.pred[k] = v;
      e.res[k*DW +: DW] = act[pick] ? laneData[pick*DW +: DW] : '0;
    end
    q.push_back(e);
    @(negedge clk);
    mode = m; offB = b; ctrlC = c; activeMask = act; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops and compares when done is seen.
  always @(negedge clk) begin
    if (rstN && done) begin
      if (q.size() == 0) begin
        chk("R1", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        int bad;
        e = q.pop_front();
        popped++;
        bad = -1;
        for (int k = LANES - 1; k >= 0; k--)
          if (result[k*DW +: DW] !== e.res[k*DW +: DW]) bad = k;
        if (bad >= 0)
          chk(e.tag, $sformatf("result lane %0d", bad),
              64'(result[bad*DW +: DW]), 64'(e.res[bad*DW +: DW]));
        else chk(e.tag, "result", 0, 0);
        chk(e.tag == "R9" ? "R9" : "R7", $sformatf("inRange (%s)", e.tag),
            64'(inRange), 64'(e.pred));
        chk("R9", $sformatf("modeErr (%s)", e.tag), 64'(modeErr), 64'(e.err));
        lastExp = e;
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10", "done", 64'(done), 0);
        chk("R10", "modeErr", 64'(modeErr), 0);
        chk("R10", "inRange", 64'(inRange), 0);
        chk("R10", "result nonzero", 64'(|result), 0);
        rstN = 1'b1;
        @(negedge clk);
        issue("R3", 3'd0, 32'd1, 32'h0, 32'hFFFF_FFFF, 1);
        issue("R3", 3'd0, 32'd0, 32'h0, 32'hFFFF_FFFF, 2);
        issue("R3", 3'd0, 32'd2, 32'h0000_1805, 32'hFFFF_FFFF, 3);
        issue("R4", 3'd1, 32'd3, 32'h1F, 32'hFFFF_FFFF, 4);
        issue("R4", 3'd1, 32'd2, 32'h0000_1807, 32'hFFFF_FFFF, 5);
        issue("R5", 3'd2, 32'd5, 32'h1F, 32'hFFFF_FFFF, 6);
        issue("R5", 3'd2, 32'd9, 32'h0000_1807, 32'hFFFF_FFFF, 7);
        issue("R6", 3'd3, 32'd7, 32'h1F, 32'hFFFF_FFFF, 8);
        issue("R6", 3'd3, 32'd3, 32'h0000_1807, 32'hFFFF_FFFF, 9);
        issue("R6", 3'd3, 32'd20, 32'h0000_0F0F, 32'hFFFF_FFFF, 10);
        issue("R2", 3'd1, 32'hFFFF_FFE1, 32'hABCD_E0FF, 32'hFFFF_FFFF, 11);
        issue("R8", 3'd0, 32'd1, 32'h0, 32'h5555_5555, 12);
        issue("R9", 3'd5, 32'd1, 32'h1F, 32'hFFFF_0FFF, 13);
        issue("R9", 3'd7, 32'd4, 32'h0, 32'hFFFF_FFFF, 14);
        issue("R4", 3'd1, 32'd31, 32'h1F, 32'hFFFF_FFFF, 15);
        // R1: done drops and outputs hold while start stays low
        offB = 32'd9; mode = 3'd2; ctrlC = 32'h1F;
        repeat (4) @(negedge clk);
        chk("R1", "done after idle", 64'(done), 0);
        chk("R1", "result held", 64'(result === lastExp.res), 1);
        chk("R1", "inRange held", 64'(inRange), 64'(lastExp.pred));
        chk("R1", "items seen", 64'(popped), 15);
      end
      begin
        repeat (20000) @(negedge clk);
        chk("R1", "watchdog expired", 1, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule